// File: doc/BRIEF.md
# PLL Output Rate Calculator

This block takes a 32-bit PLL control word and a reference frequency in Hz. It works out the frequency the PLL would produce from them, in Hz. The control word holds a power-down flag, a bypass flag and three divider codes. A normal configuration gives reference × feedback ÷ (input × output). Bypass passes the reference through unchanged, and power-down gives zero. The codes are not plain counts:

- The input divider is its code plus one.
- The feedback multiplier is twice its code plus one.
- The output divider is two raised to its code.

A one-cycle start pulse latches both inputs. A multiplier forms the 64-bit product of reference and feedback. The product then goes to an iterative restoring divider, which produces a fixed number of quotient bits per cycle. The divider divides by the input divider only. Because the output divider is a power of two, the quotient is then shifted right by its code, which equals dividing by the full product.

A parameter can instead select division by the full divisor product. Busy stays high while a calculation runs, and a single-cycle done pulse marks a valid result. The result is then held until the next calculation completes. Start requests are ignored while busy.

Top module: `pll_rate_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `rate_hz` is 0.
- R2: When `ctrl_word[1]`=0 and `ctrl_word[0]`=0, the result is floor(ref × 2·(F+1) / ((I+1) · 2^O)). Here F = `ctrl_word[15:9]`, I = `ctrl_word[8:4]` and O = `ctrl_word[3:2]`, and the product is formed at 64 bits.
- R3: When `ctrl_word[1]`=1 (bypass), the result equals `ref_hz`, whatever the other bits hold, including `ctrl_word[0]`.
- R4: When `ctrl_word[1]`=0 and `ctrl_word[0]`=1 (power-down), the result is 0.
- R5: Bits 31:16 of `ctrl_word` have no effect on the result.
- R6: For a normal configuration, `done` is first seen high after the 66th rising edge, counting the edge that samples `start`. That is PROD_W/DIV_STEP + 2 edges with the defaults 64 and 1. `busy` is high from the first edge through the done cycle.
- R7: For bypass or power-down, `done` and `busy` are high together after the first edge, for one cycle only.
- R8: `done` is high for exactly one cycle. `rate_hz` changes only in a done cycle and holds its value afterwards.
- R9: A `start` raised while `busy` is high is ignored, including a `start` raised in the done cycle. No extra `done` follows, and the result stays that of the first request.
- R10: `ctrl_word` and `ref_hz` are captured at the accepted `start`. Changing them later does not alter that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a calculation; taken only when idle |
| ctrl_word | input | 32 | PLL control word |
| ref_hz | input | 32 | Reference frequency in Hz |
| busy | output | 1 | Calculation in progress (including the done cycle) |
| done | output | 1 | One-cycle pulse: `rate_hz` is valid |
| rate_hz | output | 64 | Computed output frequency in Hz |

## Verification
Completion and a new request can fall in the same cycle: a `start` can be high exactly while `done` pulses. The bench provokes this in scrambled runs. It holds `start` high with altered control word and reference through every busy cycle, including the done cycle, and then releases it. The case is judged at the ports. The returned rate must match the model for the original inputs. The latency must be unchanged. For the following cycles `done` and `busy` must stay low and `rate_hz` must not move, which shows that the overlapping request was dropped rather than queued.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;

   // Control word field layout (bit positions are part of the behaviour)
   localparam int PD_BIT  = 0;
   localparam int BYP_BIT = 1;
   localparam int OD_LSB  = 2;
   localparam int OD_W    = 2;
   localparam int ID_LSB  = 4;
   localparam int ID_W    = 5;
   localparam int FB_LSB  = 9;
   localparam int FB_W    = 7;
   localparam int FIELD_TOP = FB_LSB + FB_W - 1;

   // Effective value widths
   localparam int IDIV_W  = ID_W + 1;        // code + 1, up to 2^ID_W
   localparam int FBMUL_W = FB_W + 2;        // 2 * (code + 1), up to 2^(FB_W+1)

   typedef struct packed {
      logic            pd;
      logic            byp;
      logic [OD_W-1:0] od;
      logic [ID_W-1:0] id;
      logic [FB_W-1:0] fb;
   } pll_fields_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } calc_state_t;

endpackage

// File: rtl/pll_ctrl_decode.sv
module pll_ctrl_decode
   import pll_rate_pkg::*;
#(
   parameter int CTRL_W = 32
) (
   input  logic [CTRL_W-1:0]  ctrl,
   output pll_fields_t        fields,
   output logic [IDIV_W-1:0]  idiv,
   output logic [FBMUL_W-1:0] fbmul
);

   initial begin
      assert (CTRL_W > FIELD_TOP)
         else $error("CTRL_W too narrow for the divider fields");
   end

   always_comb begin
      fields.pd  = ctrl[PD_BIT];
      fields.byp = ctrl[BYP_BIT];
      fields.od  = ctrl[OD_LSB +: OD_W];
      fields.id  = ctrl[ID_LSB +: ID_W];
      fields.fb  = ctrl[FB_LSB +: FB_W];
   end

   assign idiv  = IDIV_W'(fields.id) + IDIV_W'(1);
   assign fbmul = {FBMUL_W'(fields.fb) + FBMUL_W'(1)} << 1;

   // Bits above the divider fields take no part in the calculation
   generate
      if (CTRL_W > FIELD_TOP + 1) begin : g_hi
         logic unused_hi_bits;
         assign unused_hi_bits = ^ctrl[CTRL_W-1:FIELD_TOP+1];
      end
   endgenerate

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
   parameter int N_W  = 64,
   parameter int D_W  = 6,
   parameter int STEP = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic [N_W-1:0] dividend,
   input  logic [D_W-1:0] divisor,
   output logic           active,
   output logic           fin,
   output logic [N_W-1:0] quotient
);

   localparam int ITERS = N_W / STEP;
   localparam int CNT_W = $clog2(ITERS + 1);
   localparam int CHK_W = N_W + D_W + 1;

   initial begin
      assert (STEP >= 1 && (N_W % STEP) == 0)
         else $error("STEP must divide N_W");
      assert (D_W >= 1 && N_W >= 2)
         else $error("divider widths out of range");
   end

   logic [N_W-1:0]   q_r;
   logic [D_W:0]     r_r;
   logic [D_W-1:0]   d_r;
   logic [N_W-1:0]   n_r;
   logic [CNT_W-1:0] cnt_r;
   logic [N_W-1:0]   q_nx;
   logic [D_W:0]     r_nx;

   // STEP restoring iterations per clock
   always_comb begin
      logic [N_W-1:0] tq;
      logic [D_W:0]   tr;
      tq = q_r;
      tr = r_r;
      for (int i = 0; i < STEP; i++) begin
         tr = {tr[D_W-1:0], tq[N_W-1]};
         tq = {tq[N_W-2:0], 1'b0};
         if (tr >= {1'b0, d_r}) begin
            tr    = tr - {1'b0, d_r};
            tq[0] = 1'b1;
         end
      end
      q_nx = tq;
      r_nx = tr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         r_r    <= '0;
         d_r    <= '0;
         n_r    <= '0;
         cnt_r  <= '0;
         active <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (ld) begin
            q_r    <= dividend;
            r_r    <= '0;
            d_r    <= divisor;
            n_r    <= dividend;
            cnt_r  <= CNT_W'(ITERS);
            active <= 1'b1;
         end else if (active) begin
            q_r   <= q_nx;
            r_r   <= r_nx;
            cnt_r <= cnt_r - CNT_W'(1);
            if (cnt_r == CNT_W'(1)) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end
         end
      end
   end

   assign quotient = q_r;

   logic [CHK_W-1:0] recon;
   assign recon = (CHK_W'(q_r) * CHK_W'(d_r)) + CHK_W'(r_r);

   // R2
   div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (recon == CHK_W'(n_r)) && (r_r < {1'b0, d_r}));

   // R2
   nonzero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |-> (divisor != '0));

   // R8
   fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
   import pll_rate_pkg::*;
#(
   parameter int CTRL_W     = 32,
   parameter int REF_W      = 32,
   parameter int PROD_W     = 64,
   parameter int DIV_STEP   = 1,
   parameter bit SHIFT_ODIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic [REF_W-1:0]  ref_hz,
   output logic              busy,
   output logic              done,
   output logic [PROD_W-1:0] rate_hz
);

   localparam int OD_MAX = (1 << OD_W) - 1;
   localparam int DEN_W  = SHIFT_ODIV ? IDIV_W : IDIV_W + OD_MAX;

   initial begin
      assert (PROD_W >= REF_W + FBMUL_W)
         else $error("PROD_W cannot hold reference times feedback");
      assert (PROD_W >= REF_W)
         else $error("PROD_W narrower than reference");
   end

   pll_fields_t        dec_f;
   logic [IDIV_W-1:0]  dec_idiv;
   logic [FBMUL_W-1:0] dec_fbmul;

   pll_ctrl_decode #(.CTRL_W(CTRL_W)) u_dec (
      .ctrl   (ctrl_word),
      .fields (dec_f),
      .idiv   (dec_idiv),
      .fbmul  (dec_fbmul)
   );

   calc_state_t       st;
   logic              accept;
   logic              div_ld;
   logic              div_active;
   logic              div_fin;
   logic [PROD_W-1:0] div_quo;
   logic [PROD_W-1:0] prod;
   logic [DEN_W-1:0]  den;
   logic [PROD_W-1:0] quo_adj;
   logic              byp_q;
   logic              pd_q;
   logic [OD_W-1:0]   osh_q;
   logic [REF_W-1:0]  ref_q;
   logic [PROD_W-1:0] rate_q;

   assign accept = start && (st == ST_IDLE);
   assign div_ld = accept && !dec_f.byp && !dec_f.pd;
   assign prod   = PROD_W'(ref_hz) * PROD_W'(dec_fbmul);

   generate
      if (SHIFT_ODIV) begin : g_shift
         // divide by the input divider, then shift by the output code
         assign den     = dec_idiv;
         assign quo_adj = div_quo >> osh_q;
      end else begin : g_full
         // divide by the whole input x output product
         assign den     = DEN_W'(dec_idiv) << dec_f.od;
         assign quo_adj = div_quo;
      end
   endgenerate

   pll_seq_div #(
      .N_W  (PROD_W),
      .D_W  (DEN_W),
      .STEP (DIV_STEP)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (div_ld),
      .dividend (prod),
      .divisor  (den),
      .active   (div_active),
      .fin      (div_fin),
      .quotient (div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         byp_q  <= 1'b0;
         pd_q   <= 1'b0;
         osh_q  <= '0;
         ref_q  <= '0;
         rate_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  byp_q <= dec_f.byp;
                  pd_q  <= dec_f.pd;
                  osh_q <= dec_f.od;
                  ref_q <= ref_hz;
                  if (dec_f.byp) begin
                     rate_q <= PROD_W'(ref_hz);
                     st     <= ST_FIN;
                  end else if (dec_f.pd) begin
                     rate_q <= '0;
                     st     <= ST_FIN;
                  end else begin
                     st <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (div_fin) begin
                  rate_q <= quo_adj;
                  st     <= ST_FIN;
               end
            end
            ST_FIN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign done    = (st == ST_FIN);
   assign rate_hz = rate_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_hz != $past(rate_hz)) |-> done);

   // R9
   ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> $stable(ref_q) && $stable(byp_q) && $stable(pd_q));

   // R3
   byp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && byp_q) |-> (rate_hz == PROD_W'(ref_q)));

   // R4
   pd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pd_q && !byp_q) |-> (rate_hz == '0));

   // R6
   run_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_active |-> (busy && !done));

endmodule

// File: tb/sim_pll_rate_calc.sv
module sim_pll_rate_calc;

   localparam int PROD_W   = 64;
   localparam int DIV_STEP = 1;
   localparam int LAT_RUN  = PROD_W / DIV_STEP + 2;

   logic        clk;
   logic        rst_n;
   logic        start;
   logic [31:0] ctrl;
   logic [31:0] refh;
   logic        busy;
   logic        done;
   logic [63:0] rate;

   int checks;
   int errors;
   bit finished;

   pll_rate_calc #(
      .CTRL_W(32), .REF_W(32), .PROD_W(PROD_W), .DIV_STEP(DIV_STEP), .SHIFT_ODIV(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl), .ref_hz(refh),
      .busy(busy), .done(done), .rate_hz(rate)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [31:0] cw, input logic [31:0] rf);
      logic [63:0] fbm, idv, odv;
      if (cw[1]) return 64'(rf);
      if (cw[0]) return 64'd0;
      fbm = 64'(2 * (int'(cw[15:9]) + 1));
      idv = 64'(int'(cw[8:4]) + 1);
      odv = 64'd1 << cw[3:2];
      return (64'(rf) * fbm) / (idv * odv);
   endfunction

   function automatic logic [31:0] mkcw(input int fb, input int id, input int od,
                                        input bit pd, input bit byp, input logic [15:0] hi);
      return {hi, 7'(fb), 5'(id), 2'(od), byp, pd};
   endfunction

   task automatic run(input logic [31:0] cw, input logic [31:0] rf, input bit scram,
                      input string tag);
      int lat;
      logic [63:0] res;
      int exp_lat;
      exp_lat = (cw[1] || cw[0]) ? 1 : LAT_RUN;
      @(negedge clk);
      start = 1'b1;
      ctrl  = cw;
      refh  = rf;
      lat   = 0;
      forever begin
         @(posedge clk);
         @(negedge clk);
         lat++;
         if (done || lat > LAT_RUN + 10) break;
         if (!busy) begin
            errors++; checks++;
            $display("FAIL R6 busy low while waiting actual=0 expected=1");
         end
         if (scram) begin
            start = 1'b1;
            ctrl  = ~cw;
            refh  = rf ^ 32'h5A5A_1234;
         end else begin
            start = 1'b0;
         end
      end
      res = rate;
      chk({tag, " result"}, res, model(cw, rf));
      chk(((cw[1] || cw[0]) ? "R7 latency" : "R6 latency"), 64'(lat), 64'(exp_lat));
      chk("R6 busy in done cycle", 64'(busy), 64'd1);
      if (scram) begin
         // start stays high during the done cycle (R9)
         @(posedge clk);
         @(negedge clk);
      end
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R8 done single", 64'(done), 64'd0);
         chk("R9 no extra busy", 64'(busy), 64'd0);
         chk("R8 rate held", rate, res);
      end
   endtask

   initial begin
      #(10 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int fbs[4];
      int ids[4];
      logic [31:0] refs[3];
      fbs  = '{0, 11, 47, 127};
      ids  = '{0, 1, 7, 31};
      refs = '{32'd33333333, 32'hFFFF_FFFF, 32'd27000000};
      checks = 0;
      errors = 0;
      finished = 1'b0;
      start = 1'b0;
      ctrl  = '0;
      refh  = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 rate", rate, 64'd0);
      rst_n = 1'b1;

      // R2 reference point: 33.333333 MHz, codes fb 11, id 0, od 3 -> 99999999
      run(mkcw(11, 0, 3, 0, 0, 16'h0), 32'd33333333, 0, "R2 point");
      chk("R2 point value", rate, 64'd99999999);

      // R2 sweep, with bits 31:16 toggled on half the cases (R5)
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int od = 0; od < 4; od++)
               for (int r = 0; r < 3; r++)
                  run(mkcw(fbs[a], ids[b], od, 0, 0, ((a + od) % 2 == 1) ? 16'hA5C3 : 16'h0),
                      refs[r], 0, ((a + od) % 2 == 1) ? "R5 band ignored" : "R2 sweep");

      // R3 bypass wins over power-down and over every divider code
      run(mkcw(127, 31, 3, 1, 1, 16'hFFFF), 32'hDEAD_BEEF, 0, "R3 bypass+pd");
      run(mkcw(5, 3, 1, 0, 1, 16'h0), 32'd27000000, 0, "R3 bypass");
      // R4 power-down
      run(mkcw(47, 1, 2, 1, 0, 16'h0), 32'd33333333, 0, "R4 powerdown");
      run(mkcw(0, 0, 0, 1, 0, 16'h1234), 32'hFFFF_FFFF, 0, "R4 powerdown");

      // R9 / R10 start held high with altered inputs through the run
      run(mkcw(23, 0, 1, 0, 0, 16'h0), 32'd33333333, 1, "R10 scrambled");
      run(mkcw(127, 31, 0, 0, 0, 16'h0), 32'hFFFF_FFFF, 1, "R9 scrambled");
      run(mkcw(1, 2, 2, 0, 1, 16'h0), 32'd1000, 1, "R9 bypass scrambled");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule